// File: doc/BRIEF.md
# Wakeup Interrupt Aggregation Controller

This block collects interrupt requests for an always-on processor domain into a single 32-bit status word. Three kinds of source are gathered: one non-maskable pad input, eighteen direct interrupt lines, and a bank of up to 128 multiplexed lines. The multiplexed lines carry the same numbers as the first 128 shared interrupt numbers of the main interrupt controller. The pad input passes through a selectable trigger stage (low level, high level, falling edge or rising edge) into a sticky latch. Software clears that latch by writing a one.

The multiplexed lines are gated one by one through a 128-bit select bitmap, which is indexed by interrupt number. They are then ORed in groups of eight, and each group drives one status bit. The select slots that overlap the non-maskable and direct numbers (32 to 50), and every slot from 100 upward, are not implemented. Every status bit is ANDed with an enable bit before it is read. A registered output is raised whenever any enabled bit is pending. All external inputs pass through a two-flop synchronizer first. Software reaches the pending, enable, trigger-mode and select registers through a simple single-cycle register port with registered read data.

Top module: `wake_irq_aggregator`

## Requirements
- R1: After reset, the pending, enable and select registers read 0, the trigger-mode register reads 3 (rising edge), and `irq_out` is 0.
- R2: Word address 0 is pending, 1 is enable, 2 is trigger mode (bits 1:0), and 4 to 7 are select words 0 to 3 (word w holds lines 32w to 32w+31). Address 3 reads 0. Read data appears on the clock edge after the address is presented.
- R3: The trigger-mode encoding is 0 low level, 1 high level, 2 falling edge, 3 rising edge. A matching condition on the synchronized pad sets the non-maskable latch.
- R4: Writing 1 to pending bit 0 clears the latch. If the trigger condition is active in the same cycle, the set wins, so a held active level keeps the latch at 1.
- R5: Pending bit 0 reads the latch ANDed with enable bit 0.
- R6: Pending bit 1+i (i = 0 to 17) reads the synchronized direct line i ANDed with enable bit 1+i.
- R7: Multiplexed line m is gated by select bit m and reported in pending bit 19+floor(m/8), ANDed with that bit's enable. Lines 0 to 7 all land in bit 19.
- R8: Select bits 32 to 50 and 100 to 127 are unimplemented. They read 0, ignore writes, and their lines never affect pending.
- R9: Writing to pending bits 1 to 31 has no effect. Writing 0 to bit 0 leaves the latch unchanged.
- R10: In edge modes the latch stays set after the pad returns to its idle level, until it is cleared.
- R11: `irq_out` is a registered OR of the enabled pending vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nmi_pad | input | 1 | Non-maskable pad interrupt, asynchronous |
| direct_irq | input | 18 | Direct interrupt lines, asynchronous |
| mux_irq | input | 128 | Multiplexed interrupt lines, indexed by shared interrupt number |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for `reg_addr` |
| irq_out | output | 1 | Aggregated interrupt request |

## Verification
A wrong latch state shows up in pending bit 0 and in `irq_out` within one to two cycles of the faulty update. That makes the set-over-clear priority and the edge-hold behaviour visible at the ports. A select bitmap that stores unimplemented bits shows in two ways: the corrupted slots read back nonzero on the next read of that word, and a pending group bit stays high while all of its legal lines are silent. Wrong grouping or wrong gating appears in the pending read about four cycles after the input changes, once the synchronizer and the registers have settled. Random line, enable and select patterns are compared against a model of the status layout.

// File: rtl/wia_pkg.sv
package wia_pkg;

  typedef enum logic [1:0] {
    TRIG_LOW  = 2'd0,
    TRIG_HIGH = 2'd1,
    TRIG_FALL = 2'd2,
    TRIG_RISE = 2'd3
  } trig_mode_e;

  // A select slot exists unless it overlaps the numbers owned by the
  // non-maskable/direct sources or lies at or above the implemented limit.
  function automatic logic sel_slot_exists(input int m, input int hole_lo,
                                           input int hole_len, input int limit);
    return (m < limit) && !((m >= hole_lo) && (m < hole_lo + hole_len));
  endfunction

endpackage

// File: rtl/wia_sync.sv
module wia_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/wia_nmi_stage.sv
module wia_nmi_stage
  import wia_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       pad_s,
  input  trig_mode_e mode,
  input  logic       clr,
  output logic       latched
);
  logic prev;
  logic fire;

  always_comb begin
    unique case (mode)
      TRIG_LOW:  fire = ~pad_s;
      TRIG_HIGH: fire = pad_s;
      TRIG_FALL: fire = ~pad_s & prev;
      default:   fire = pad_s & ~prev;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev    <= 1'b0;
      latched <= 1'b0;
    end else begin
      prev <= pad_s;
      if (fire)      latched <= 1'b1;
      else if (clr)  latched <= 1'b0;
    end
  end

  p_rise_sets_r3: assert property (@(posedge clk) disable iff (rst)
    (mode == TRIG_RISE && pad_s && !prev) |=> latched);
  p_high_holds_r4: assert property (@(posedge clk) disable iff (rst)
    (mode == TRIG_HIGH && pad_s && clr) |=> latched);
  p_clear_r4: assert property (@(posedge clk) disable iff (rst)
    (clr && mode == TRIG_RISE && !(pad_s && !prev)) |=> !latched);
  p_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    (latched && !clr) |=> latched);
endmodule

// File: rtl/wia_mux_groups.sv
module wia_mux_groups #(
  parameter int GROUP    = 8,
  parameter int N_GROUPS = 13,
  localparam int COVER   = GROUP * N_GROUPS
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [COVER-1:0]    lines,
  input  logic [COVER-1:0]    sel,
  output logic [N_GROUPS-1:0] grp
);
  logic [COVER-1:0] gated;
  assign gated = lines & sel;

  for (genvar g = 0; g < N_GROUPS; g++) begin : g_grp
    assign grp[g] = |gated[g*GROUP +: GROUP];
  end

  p_silent_r7: assert property (@(posedge clk) disable iff (rst)
    ((lines & sel) == '0) |-> (grp == '0));
endmodule

// File: rtl/wake_irq_aggregator.sv
module wake_irq_aggregator
  import wia_pkg::*;
#(
  parameter int N_DIRECT  = 18,
  parameter int N_MUX     = 128,
  parameter int GROUP     = 8,
  parameter int N_GROUPS  = 13,
  parameter int NMI_SLOT  = 32,
  parameter int SEL_LIMIT = 100,
  parameter int ADDR_W    = 3,
  parameter int DATA_W    = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                nmi_pad,
  input  logic [N_DIRECT-1:0] direct_irq,
  input  logic [N_MUX-1:0]    mux_irq,
  input  logic                reg_wr,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [DATA_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0]   reg_rdata,
  output logic                irq_out
);
  localparam int STAT_W    = 1 + N_DIRECT + N_GROUPS;
  localparam int COVER     = GROUP * N_GROUPS;
  localparam int SEL_WORDS = N_MUX / DATA_W;
  localparam int SEL_BASE  = 4;
  localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(2);

  logic [N_MUX-1:0]    sel_mask;
  logic [N_MUX-1:0]    sel_q;
  logic [STAT_W-1:0]   en_q;
  trig_mode_e          mode_q;
  logic                pad_s;
  logic [N_DIRECT-1:0] dir_s;
  logic [COVER-1:0]    mux_s;
  logic [N_GROUPS-1:0] grp;
  logic                latched;
  logic                clr_nmi;
  logic [STAT_W-1:0]   raw_vec;
  logic [STAT_W-1:0]   pend_vec;
  logic [DATA_W-1:0]   rd_next;
  logic                unused_hi;

  for (genvar m = 0; m < N_MUX; m++) begin : g_mask
    assign sel_mask[m] = sel_slot_exists(m, NMI_SLOT, 1 + N_DIRECT, SEL_LIMIT);
  end

  assign unused_hi = ^mux_irq[N_MUX-1:COVER];

  wia_sync #(.W(1)) i_sync_pad (
    .clk(clk), .rst(rst), .d(nmi_pad), .q(pad_s)
  );
  wia_sync #(.W(N_DIRECT)) i_sync_dir (
    .clk(clk), .rst(rst), .d(direct_irq), .q(dir_s)
  );
  wia_sync #(.W(COVER)) i_sync_mux (
    .clk(clk), .rst(rst), .d(mux_irq[COVER-1:0]), .q(mux_s)
  );

  assign clr_nmi = reg_wr && (reg_addr == A_PEND) && reg_wdata[0];

  wia_nmi_stage i_nmi (
    .clk(clk), .rst(rst), .pad_s(pad_s), .mode(mode_q),
    .clr(clr_nmi), .latched(latched)
  );

  wia_mux_groups #(.GROUP(GROUP), .N_GROUPS(N_GROUPS)) i_groups (
    .clk(clk), .rst(rst), .lines(mux_s), .sel(sel_q[COVER-1:0]), .grp(grp)
  );

  assign raw_vec  = {grp, dir_s, latched};
  assign pend_vec = raw_vec & en_q;

  // Register writes
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      mode_q <= TRIG_RISE;
      sel_q  <= '0;
    end else if (reg_wr) begin
      if (reg_addr == A_EN)   en_q   <= reg_wdata[STAT_W-1:0];
      if (reg_addr == A_MODE) mode_q <= trig_mode_e'(reg_wdata[1:0]);
      for (int w = 0; w < SEL_WORDS; w++) begin
        if (reg_addr == ADDR_W'(SEL_BASE + w))
          sel_q[w*DATA_W +: DATA_W] <= reg_wdata & sel_mask[w*DATA_W +: DATA_W];
      end
    end
  end

  // Read mux
  always_comb begin
    rd_next = '0;
    if (reg_addr == A_PEND)      rd_next[STAT_W-1:0] = pend_vec;
    else if (reg_addr == A_EN)   rd_next[STAT_W-1:0] = en_q;
    else if (reg_addr == A_MODE) rd_next[1:0]        = mode_q;
    for (int w = 0; w < SEL_WORDS; w++) begin
      if (reg_addr == ADDR_W'(SEL_BASE + w)) rd_next = sel_q[w*DATA_W +: DATA_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
      irq_out   <= 1'b0;
    end else begin
      reg_rdata <= rd_next;
      irq_out   <= |pend_vec;
    end
  end

  p_no_hole_bits_r8: assert property (@(posedge clk) disable iff (rst)
    ((sel_q & ~sel_mask) == '0));
  p_irq_up_r11: assert property (@(posedge clk) disable iff (rst)
    (|pend_vec) |=> irq_out);
  p_irq_down_r11: assert property (@(posedge clk) disable iff (rst)
    (!(|pend_vec)) |=> !irq_out);
  p_en_stable_r9: assert property (@(posedge clk) disable iff (rst)
    !(reg_wr && reg_addr == A_EN) |=> $stable(en_q));
endmodule

// File: tb/test_wake_irq_aggregator.sv
module test_wake_irq_aggregator;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         nmi_pad = 1'b0;
  logic [17:0]  direct_irq = '0;
  logic [127:0] mux_irq = '0;
  logic         reg_wr = 1'b0;
  logic [2:0]   reg_addr = '0;
  logic [31:0]  reg_wdata = '0;
  logic [31:0]  reg_rdata;
  logic         irq_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  wake_irq_aggregator i_wake_irq_aggregator (
    .clk(clk), .rst(rst), .nmi_pad(nmi_pad), .direct_irq(direct_irq),
    .mux_irq(mux_irq), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_out(irq_out)
  );

  function automatic logic [127:0] sel_mask_model();
    logic [127:0] r = '0;
    for (int m = 0; m < 100; m++) if (m < 32 || m > 50) r[m] = 1'b1;
    return r;
  endfunction

  function automatic logic [31:0] pend_model(logic lat, logic [17:0] d,
      logic [127:0] mx, logic [127:0] sel, logic [31:0] en);
    logic [31:0] r;
    logic [127:0] g = mx & sel & sel_mask_model();
    r[0] = lat;
    r[18:1] = d;
    for (int k = 0; k < 13; k++) r[19+k] = |g[k*8 +: 8];
    return r & en;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [127:0] selv;
    logic [31:0] env;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset values
    check("R1 irq_out", {31'd0, irq_out}, 32'd0);
    rd(3'd0, v); check("R1 pend", v, 32'd0);
    rd(3'd1, v); check("R1 enable", v, 32'd0);
    rd(3'd2, v); check("R1 mode", v, 32'd3);
    for (int w = 0; w < 4; w++) begin
      rd(3'(4 + w), v); check("R1 sel", v, 32'd0);
    end
    rd(3'd3, v); check("R2 addr3 zero", v, 32'd0);

    // R2 register map read-back
    wr(3'd1, 32'hFFFF_FFFF);
    rd(3'd1, v); check("R2 enable readback", v, 32'hFFFF_FFFF);

    // R3/R5 rising edge sets latch, R10 holds after pad falls
    nmi_pad = 1'b1; settle();
    rd(3'd0, v); check("R3 rise sets latch", v, 32'h1);
    check("R11 irq up", {31'd0, irq_out}, 32'd1);
    nmi_pad = 1'b0; settle();
    rd(3'd0, v); check("R10 latch sticky", v, 32'h1);
    wr(3'd1, 32'hFFFF_FFFE); settle();
    rd(3'd0, v); check("R5 enable gates bit0", v, 32'h0);
    check("R11 irq follows enable", {31'd0, irq_out}, 32'd0);
    wr(3'd1, 32'hFFFF_FFFF);
    wr(3'd0, 32'hFFFF_FFFE); settle();
    rd(3'd0, v); check("R9 w0 bit0 keeps latch", v, 32'h1);
    wr(3'd0, 32'h1); settle();
    rd(3'd0, v); check("R4 clear", v, 32'h0);

    // R3 high level, R4 set wins over clear
    wr(3'd2, 32'd1);
    rd(3'd2, v); check("R2 mode readback", v, 32'd1);
    nmi_pad = 1'b1; settle();
    wr(3'd0, 32'h1); settle();
    rd(3'd0, v); check("R4 level wins over clear", v, 32'h1);
    nmi_pad = 1'b0; settle();
    wr(3'd0, 32'h1); settle();
    rd(3'd0, v); check("R4 clear after level gone", v, 32'h0);

    // R3 falling edge
    wr(3'd2, 32'd2);
    nmi_pad = 1'b1; settle();
    rd(3'd0, v); check("R3 falling idle", v, 32'h0);
    nmi_pad = 1'b0; settle();
    rd(3'd0, v); check("R3 falling sets", v, 32'h1);
    wr(3'd0, 32'h1); settle();
    // R3 low level
    wr(3'd2, 32'd0); settle();
    rd(3'd0, v); check("R3 low level sets", v, 32'h1);
    wr(3'd2, 32'd3); wr(3'd0, 32'h1); settle();
    rd(3'd0, v); check("R4 clear back to rise", v, 32'h0);

    // R7 lines 0..7 share bit 19
    wr(3'd4, 32'h0000_0081);
    mux_irq = 128'h80; settle();
    rd(3'd0, v); check("R7 line7 bit19", v, 32'h0008_0000);
    mux_irq = 128'h2; settle();
    rd(3'd0, v); check("R7 unselected line1", v, 32'h0);

    // R8 hole and upper slots
    wr(3'd5, 32'hFFFF_FFFF);
    rd(3'd5, v); check("R8 hole readback", v, 32'hFFF8_0000);
    wr(3'd7, 32'hFFFF_FFFF);
    rd(3'd7, v); check("R8 top readback", v, 32'h0000_000F);
    mux_irq = '0; mux_irq[40] = 1'b1; mux_irq[101] = 1'b1; settle();
    rd(3'd0, v); check("R8 hole lines silent", v, 32'h0);

    // Random patterns R6 R7 R9 R11
    for (int it = 0; it < 60; it++) begin
      direct_irq = 18'($urandom);
      mux_irq = {$urandom, $urandom, $urandom, $urandom};
      selv = {$urandom, $urandom, $urandom, $urandom};
      env = $urandom & 32'hFFFF_FFFE;
      for (int w = 0; w < 4; w++) wr(3'(4 + w), selv[w*32 +: 32]);
      wr(3'd1, env);
      if (it % 3 == 0) wr(3'd0, $urandom & 32'hFFFF_FFFE);
      settle();
      rd(3'd0, v);
      check("R6 R7 R9 random pend", v, pend_model(1'b0, direct_irq, mux_irq, selv, env));
      check("R11 random irq", {31'd0, irq_out}, {31'd0, |pend_model(1'b0, direct_irq, mux_irq, selv, env)});
      rd(3'(4 + it % 4), v);
      check("R8 random sel", v, (selv & sel_mask_model()) >> (32 * (it % 4)));
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule